// File: doc/BRIEF.md
# SPI FIFO Byte Packer

This block converts between the 32-bit words of a serial master's transmit and receive FIFOs and the byte streams that software-side logic produces and consumes. On the transmit path it gathers bytes into FIFO words. The first byte of every word sits in the most significant lane, and any unused low lanes are zero. On the receive path it takes FIFO words whose used part is right-justified and emits their bytes, most significant used byte first.

The number of bytes carried per serial word is set by a five-bit configuration field that holds the bits-per-word value minus one. A start pulse loads this field together with the transfer length in bytes and two mode bits. One mode bit makes the transmit side push all-zero words without taking any bytes. The other makes the receive side pop words and throw them away. Both paths count bytes against the length and stop exactly on it. A partial final word is therefore pushed or trimmed. Each of the four sides uses a valid/ready handshake.

Top module: `spi_fifo_byte_packer`

## Requirements
- R1: On a start pulse the word size is decoded from `cfg_bpw_m1` (bits-per-word minus one, 3..31). Values up to 7 give 1 byte per word, values from 8 to 15 give 2 bytes, and values from 16 upward give 4 bytes.
- R2: A transmit word carries the byte with in-word index i (0 = first accepted) in bits [8*(3-i)+7 : 8*(3-i)]. Lanes beyond the word size are zero.
- R3: For a received word of w bytes, the bytes are taken from bits [8*(w-1-i)+7 : 8*(w-1-i)] for i = 0..w-1, in that order. Bits above 8*w are ignored.
- R4: The transmit side accepts exactly `cfg_len` bytes. When the length is reached inside a word, that partial word is pushed. `tx_done` is high once the length is reached and no word is pending. `tx_byte_ready` is then low.
- R5: The receive side emits exactly `cfg_len` bytes. Bytes of the last word past the length are dropped. Once the length is reached, `ififo_ready` stays low.
- R6: With `cfg_tx_none` set, `tx_byte_ready` stays low. One all-zero word is pushed for each w bytes of length, rounded up.
- R7: With `cfg_rx_none` set, the block pops one input word for each w bytes of length, rounded up, and `rx_byte_valid` stays low.
- R8: While `ofifo_ready` is low, a presented word keeps its value and no further byte is taken. While `rx_byte_ready` is low, the presented byte stays valid and stable and no further word is popped.
- R9: `rx_done` rises when the received byte count equals the length. It stays high until the next start pulse, which clears it.
- R10: After reset, `ofifo_valid`, `rx_byte_valid`, `tx_byte_ready`, `ififo_ready`, `rx_done` and `tx_done` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start | input | 1 | Loads configuration and restarts both counters |
| cfg_bpw_m1 | input | 5 | Bits per serial word minus one |
| cfg_len | input | LEN_W | Transfer length in bytes |
| cfg_tx_none | input | 1 | Transmit without data: push zero words |
| cfg_rx_none | input | 1 | Receive without buffer: discard words |
| tx_byte_valid | input | 1 | Transmit byte valid |
| tx_byte_data | input | 8 | Transmit byte |
| tx_byte_ready | output | 1 | Transmit byte accepted |
| ofifo_valid | output | 1 | Output FIFO word valid |
| ofifo_data | output | WORD_W | Output FIFO word |
| ofifo_ready | input | 1 | Output FIFO not full |
| ififo_valid | input | 1 | Input FIFO not empty |
| ififo_data | input | WORD_W | Input FIFO word |
| ififo_ready | output | 1 | Input FIFO pop |
| rx_byte_valid | output | 1 | Received byte valid |
| rx_byte_data | output | 8 | Received byte |
| rx_byte_ready | input | 1 | Received byte taken |
| tx_done | output | 1 | Transmit length reached and flushed |
| rx_done | output | 1 | Receive length reached |

## Verification
If the lane index goes wrong in either path, bytes show up in the wrong lane or in the wrong order. This is visible on the first word of a transfer with a word size above one. A byte counter that drifts shows up at the end of the transfer: the final word, or the `rx_done` edge, comes one word early or late, or the block never lets go of the FIFO handshake. The transfer lengths are chosen so that the boundary falls both on a word edge and inside a word, for every word size. The stall cases check that a held word or byte does not change while its consumer is not ready.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
   localparam int unsigned LANE_W = 8;
   typedef logic [2:0] wsize_t;

   // Byte count of one serial word from the (bits-per-word - 1) field.
   function automatic wsize_t wsize_of(input logic [4:0] n);
      if (n <= 5'd7)       return 3'd1;
      else if (n <= 5'd15) return 3'd2;
      else                 return 3'd4;
   endfunction
endpackage

// File: rtl/fbp_cfg.sv
module fbp_cfg
   import fbp_pkg::*;
#(
   parameter int LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [4:0]       bpw_m1,
   input  logic [LEN_W-1:0] len,
   input  logic             tx_none,
   input  logic             rx_none,
   output logic             armed,
   output wsize_t           wsz,
   output logic [LEN_W-1:0] len_q,
   output logic             tx_none_q,
   output logic             rx_none_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed     <= 1'b0;
         wsz       <= 3'd1;
         len_q     <= '0;
         tx_none_q <= 1'b0;
         rx_none_q <= 1'b0;
      end else if (start) begin
         armed     <= 1'b1;
         wsz       <= wsize_of(bpw_m1);
         len_q     <= len;
         tx_none_q <= tx_none;
         rx_none_q <= rx_none;
      end
   end
endmodule

// File: rtl/fbp_tx_pack.sv
module fbp_tx_pack
   import fbp_pkg::*;
#(
   parameter int LEN_W  = 16,
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              armed,
   input  wsize_t            wsz,
   input  logic [LEN_W-1:0]  len,
   input  logic              tx_none,
   input  logic              byte_valid,
   input  logic [7:0]        byte_data,
   output logic              byte_ready,
   output logic              word_valid,
   output logic [WORD_W-1:0] word_data,
   input  logic              word_ready,
   output logic              done
);
   localparam int LANES = WORD_W / LANE_W;
   localparam int IDX_W = $clog2(LANES);

   logic [LEN_W-1:0] cnt;
   logic [LEN_W-1:0] rem;
   logic [LEN_W-1:0] step;
   logic [IDX_W-1:0] idx;
   logic [IDX_W-1:0] lane_sel;
   logic             hold;
   logic             last_byte;
   logic             byte_fire;
   logic             word_fire;
   logic [7:0]       acc [LANES];

   assign rem        = len - cnt;
   assign step       = (rem < LEN_W'(wsz)) ? rem : LEN_W'(wsz);
   assign lane_sel   = IDX_W'(LANES - 1) - idx;
   assign last_byte  = (3'(idx) == wsz - 3'd1) || (rem == LEN_W'(1));
   assign byte_ready = armed && !tx_none && !hold && (rem != '0);
   assign word_valid = hold || (armed && tx_none && (rem != '0));
   assign byte_fire  = byte_valid && byte_ready;
   assign word_fire  = word_valid && word_ready;
   assign done       = armed && (rem == '0) && !hold;

   always_comb begin
      for (int l = 0; l < LANES; l++) begin
         word_data[l*LANE_W +: LANE_W] = tx_none ? 8'h00 : acc[l];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || start) begin
         cnt  <= '0;
         idx  <= '0;
         hold <= 1'b0;
      end else begin
         if (byte_fire) begin
            cnt <= cnt + LEN_W'(1);
            if (last_byte) begin
               hold <= 1'b1;
               idx  <= '0;
            end else begin
               idx <= idx + IDX_W'(1);
            end
         end
         if (word_fire) begin
            hold <= 1'b0;
            if (tx_none) cnt <= cnt + step;
         end
      end
   end

   // One accumulator lane per byte position, first byte in the top lane.
   for (genvar L = 0; L < LANES; L++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n || start || word_fire)
            acc[L] <= 8'h00;
         else if (byte_fire && (lane_sel == IDX_W'(L)))
            acc[L] <= byte_data;
      end
   end
endmodule

// File: rtl/fbp_rx_unpack.sv
module fbp_rx_unpack
   import fbp_pkg::*;
#(
   parameter int LEN_W  = 16,
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              armed,
   input  wsize_t            wsz,
   input  logic [LEN_W-1:0]  len,
   input  logic              rx_none,
   input  logic              word_valid,
   input  logic [WORD_W-1:0] word_data,
   output logic              word_ready,
   output logic              byte_valid,
   output logic [7:0]        byte_data,
   input  logic              byte_ready,
   output logic              done
);
   localparam int LANES = WORD_W / LANE_W;
   localparam int IDX_W = $clog2(LANES);

   logic [LEN_W-1:0]  cnt;
   logic [LEN_W-1:0]  rem;
   logic [2:0]        take;
   logic [2:0]        nb;
   logic [2:0]        sel;
   logic [IDX_W-1:0]  idx;
   logic              have;
   logic [WORD_W-1:0] wq;
   logic              word_fire;
   logic              byte_fire;

   assign rem        = len - cnt;
   assign take       = (rem < LEN_W'(wsz)) ? rem[2:0] : wsz;
   assign sel        = wsz - 3'd1 - 3'(idx);
   assign word_ready = armed && !have && (rem != '0);
   assign byte_valid = have;
   assign byte_data  = wq[{sel[IDX_W-1:0], 3'b000} +: LANE_W];
   assign word_fire  = word_valid && word_ready;
   assign byte_fire  = byte_valid && byte_ready;
   assign done       = armed && (rem == '0) && !have;

   always_ff @(posedge clk) begin
      if (!rst_n || start) begin
         cnt  <= '0;
         have <= 1'b0;
         idx  <= '0;
         nb   <= '0;
         wq   <= '0;
      end else begin
         if (word_fire) begin
            if (rx_none) begin
               cnt <= cnt + LEN_W'(take);
            end else begin
               have <= 1'b1;
               wq   <= word_data;
               idx  <= '0;
               nb   <= take;
            end
         end
         if (byte_fire) begin
            cnt <= cnt + LEN_W'(1);
            idx <= idx + IDX_W'(1);
            if (3'(idx) + 3'd1 == nb) have <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/spi_fifo_byte_packer.sv
module spi_fifo_byte_packer
   import fbp_pkg::*;
#(
   parameter int LEN_W  = 16,
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_start,
   input  logic [4:0]        cfg_bpw_m1,
   input  logic [LEN_W-1:0]  cfg_len,
   input  logic              cfg_tx_none,
   input  logic              cfg_rx_none,
   input  logic              tx_byte_valid,
   input  logic [7:0]        tx_byte_data,
   output logic              tx_byte_ready,
   output logic              ofifo_valid,
   output logic [WORD_W-1:0] ofifo_data,
   input  logic              ofifo_ready,
   input  logic              ififo_valid,
   input  logic [WORD_W-1:0] ififo_data,
   output logic              ififo_ready,
   output logic              rx_byte_valid,
   output logic [7:0]        rx_byte_data,
   input  logic              rx_byte_ready,
   output logic              tx_done,
   output logic              rx_done
);
   if (WORD_W != 32) begin : g_bad_word
      $error("spi_fifo_byte_packer: WORD_W must be 32");
   end
   if (LEN_W < 3) begin : g_bad_len
      $error("spi_fifo_byte_packer: LEN_W must be at least 3");
   end

   logic             armed;
   wsize_t           wsz;
   logic [LEN_W-1:0] len_q;
   logic             tx_none_q;
   logic             rx_none_q;

   fbp_cfg #(.LEN_W(LEN_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (cfg_start),
      .bpw_m1   (cfg_bpw_m1),
      .len      (cfg_len),
      .tx_none  (cfg_tx_none),
      .rx_none  (cfg_rx_none),
      .armed    (armed),
      .wsz      (wsz),
      .len_q    (len_q),
      .tx_none_q(tx_none_q),
      .rx_none_q(rx_none_q)
   );

   fbp_tx_pack #(.LEN_W(LEN_W), .WORD_W(WORD_W)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (cfg_start),
      .armed     (armed),
      .wsz       (wsz),
      .len       (len_q),
      .tx_none   (tx_none_q),
      .byte_valid(tx_byte_valid),
      .byte_data (tx_byte_data),
      .byte_ready(tx_byte_ready),
      .word_valid(ofifo_valid),
      .word_data (ofifo_data),
      .word_ready(ofifo_ready),
      .done      (tx_done)
   );

   fbp_rx_unpack #(.LEN_W(LEN_W), .WORD_W(WORD_W)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (cfg_start),
      .armed     (armed),
      .wsz       (wsz),
      .len       (len_q),
      .rx_none   (rx_none_q),
      .word_valid(ififo_valid),
      .word_data (ififo_data),
      .word_ready(ififo_ready),
      .byte_valid(rx_byte_valid),
      .byte_data (rx_byte_data),
      .byte_ready(rx_byte_ready),
      .done      (rx_done)
   );
endmodule

// File: rtl/fbp_chk.sv
module fbp_chk #(
   parameter int WORD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              tx_none_q,
   input logic              rx_none_q,
   input logic              tx_byte_ready,
   input logic              ofifo_valid,
   input logic [WORD_W-1:0] ofifo_data,
   input logic              ofifo_ready,
   input logic              ififo_ready,
   input logic              rx_byte_valid,
   input logic [7:0]        rx_byte_data,
   input logic              rx_byte_ready,
   input logic              tx_done,
   input logic              rx_done
);
   AST_TXW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ofifo_valid && !ofifo_ready && !start |=> ofifo_valid && $stable(ofifo_data)); // R8
   AST_RXB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rx_byte_valid && !rx_byte_ready && !start |=> rx_byte_valid && $stable(rx_byte_data)); // R8
   AST_TXNONE_NOBYTE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_none_q |-> !tx_byte_ready); // R6
   AST_RXNONE_NOBYTE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_none_q |-> !rx_byte_valid); // R7
   AST_DONE_NOPOP: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |-> !ififo_ready); // R5
   AST_TXDONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |-> !ofifo_valid && !tx_byte_ready); // R4
   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done && !start |=> rx_done); // R9
   AST_DONE_NOBYTE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |-> !rx_byte_valid); // R9
endmodule

bind spi_fifo_byte_packer fbp_chk #(.WORD_W(WORD_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start        (cfg_start),
   .tx_none_q    (tx_none_q),
   .rx_none_q    (rx_none_q),
   .tx_byte_ready(tx_byte_ready),
   .ofifo_valid  (ofifo_valid),
   .ofifo_data   (ofifo_data),
   .ofifo_ready  (ofifo_ready),
   .ififo_ready  (ififo_ready),
   .rx_byte_valid(rx_byte_valid),
   .rx_byte_data (rx_byte_data),
   .rx_byte_ready(rx_byte_ready),
   .tx_done      (tx_done),
   .rx_done      (rx_done)
);

// File: tb/spi_fifo_byte_packer_tb.sv
`timescale 1ns/1ps
module spi_fifo_byte_packer_tb;
   localparam int LEN_W  = 16;
   localparam int WORD_W = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_start = 1'b0;
   logic [4:0]        cfg_bpw_m1 = '0;
   logic [LEN_W-1:0]  cfg_len = '0;
   logic              cfg_tx_none = 1'b0;
   logic              cfg_rx_none = 1'b0;
   logic              tx_byte_valid = 1'b0;
   logic [7:0]        tx_byte_data = '0;
   logic              tx_byte_ready;
   logic              ofifo_valid;
   logic [WORD_W-1:0] ofifo_data;
   logic              ofifo_ready = 1'b1;
   logic              ififo_valid = 1'b0;
   logic [WORD_W-1:0] ififo_data = '0;
   logic              ififo_ready;
   logic              rx_byte_valid;
   logic [7:0]        rx_byte_data;
   logic              rx_byte_ready = 1'b1;
   logic              tx_done;
   logic              rx_done;

   always #2.5 clk = ~clk;

   spi_fifo_byte_packer #(.LEN_W(LEN_W), .WORD_W(WORD_W)) u_dut (.*);

   int n_checks = 0;
   int n_fail   = 0;
   int n_w = 0;
   int n_b = 0;
   logic [31:0] cap_w [256];
   logic [7:0]  cap_b [256];

   // {bpw_m1, len, seed}
   localparam logic [20:0] VEC [8] = '{
      {5'd3,  8'd5, 8'h10}, {5'd7,  8'd3, 8'h20},
      {5'd8,  8'd6, 8'h30}, {5'd15, 8'd5, 8'h40},
      {5'd16, 8'd8, 8'h50}, {5'd31, 8'd7, 8'h60},
      {5'd23, 8'd1, 8'h70}, {5'd12, 8'd4, 8'h80}
   };

   always @(negedge clk) begin
      if (ofifo_valid && ofifo_ready) begin
         cap_w[n_w % 256] = ofifo_data;
         n_w++;
      end
      if (rx_byte_valid && rx_byte_ready) begin
         cap_b[n_b % 256] = rx_byte_data;
         n_b++;
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int wbytes(input logic [4:0] bm);
      int bpw = int'(bm) + 1;
      if (bpw <= 8) return 1;
      if (bpw <= 16) return 2;
      return 4;
   endfunction

   function automatic logic [31:0] tx_word(input int w, input int ln, input logic [7:0] s, input int k);
      logic [31:0] r = '0;
      for (int i = 0; i < w; i++) begin
         if (k*w + i < ln) r[8*(3-i) +: 8] = 8'(s + 8'(k*w + i));
      end
      return r;
   endfunction

   function automatic logic [31:0] rx_word(input int w, input int ln, input logic [7:0] s, input int k);
      logic [31:0] r = 32'hEEEE_EEEE;
      for (int i = 0; i < w; i++) begin
         r[8*(w-1-i) +: 8] = (k*w + i < ln) ? 8'(s + 8'(k*w + i)) : 8'h5A;
      end
      return r;
   endfunction

   task automatic do_start(input logic [4:0] bm, input int ln, input bit txn, input bit rxn);
      cfg_bpw_m1 = bm; cfg_len = LEN_W'(ln); cfg_tx_none = txn; cfg_rx_none = rxn;
      cfg_start = 1'b1;
      @(negedge clk);
      cfg_start = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b);
      tx_byte_data = b; tx_byte_valid = 1'b1;
      while (!tx_byte_ready) @(negedge clk);
      @(negedge clk);
      tx_byte_valid = 1'b0;
   endtask

   task automatic push_word(input logic [31:0] d);
      ififo_data = d; ififo_valid = 1'b1;
      while (!ififo_ready) @(negedge clk);
      @(negedge clk);
      ififo_valid = 1'b0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      int wb, bb;
      repeat (3) @(negedge clk);
      // R10: reset state
      check(!ofifo_valid && !rx_byte_valid && !tx_byte_ready && !ififo_ready && !rx_done && !tx_done,
            "R10 reset outputs", {26'd0, ofifo_valid, rx_byte_valid, tx_byte_ready, ififo_ready, rx_done, tx_done}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // Vector table: R1 word size, R2 packing, R3 unpacking, R4/R5 length
      for (int v = 0; v < 8; v++) begin
         logic [4:0] bm = VEC[v][20:16];
         int ln = int'(VEC[v][15:8]);
         logic [7:0] sd = VEC[v][7:0];
         int w = wbytes(bm);
         int nwd = (ln + w - 1) / w;
         wb = n_w; bb = n_b;
         do_start(bm, ln, 1'b0, 1'b0);
         fork
            for (int j = 0; j < ln; j++) send_byte(8'(sd + 8'(j)));
            for (int k = 0; k < nwd; k++) push_word(rx_word(w, ln, 8'(sd + 8'h80), k));
         join
         repeat (8) @(negedge clk);
         check(n_w - wb == nwd, "R1 R4 word count", 32'(n_w - wb), 32'(nwd));
         for (int k = 0; k < nwd; k++)
            check(cap_w[(wb + k) % 256] == tx_word(w, ln, sd, k), "R2 tx word",
                  cap_w[(wb + k) % 256], tx_word(w, ln, sd, k));
         check(n_b - bb == ln, "R5 rx byte count", 32'(n_b - bb), 32'(ln));
         for (int j = 0; j < ln; j++)
            check(cap_b[(bb + j) % 256] == 8'(sd + 8'h80 + 8'(j)), "R3 rx byte",
                  32'(cap_b[(bb + j) % 256]), 32'(8'(sd + 8'h80 + 8'(j))));
         check(rx_done && tx_done, "R9 R4 done flags", {30'd0, rx_done, tx_done}, 32'd3);
         check(!ififo_ready && !tx_byte_ready, "R5 R4 stopped at length",
               {30'd0, ififo_ready, tx_byte_ready}, 32'd0);
      end

      // R8: stalls on both sides
      @(posedge clk); #1 ofifo_ready = 1'b0; rx_byte_ready = 1'b0;
      @(negedge clk);
      wb = n_w; bb = n_b;
      do_start(5'd7, 2, 1'b0, 1'b0);
      send_byte(8'hA1);
      repeat (3) @(negedge clk);
      check(ofifo_valid && ofifo_data == 32'hA100_0000, "R8 held word", ofifo_data, 32'hA100_0000);
      check(!tx_byte_ready, "R8 no byte while word held", {31'd0, tx_byte_ready}, 32'd0);
      push_word(32'hEEEE_EE37);
      repeat (3) @(negedge clk);
      check(rx_byte_valid && rx_byte_data == 8'h37, "R8 held byte", {23'd0, rx_byte_valid, rx_byte_data}, 32'h137);
      check(!ififo_ready, "R8 no pop while byte held", {31'd0, ififo_ready}, 32'd0);
      @(posedge clk); #1 ofifo_ready = 1'b1; rx_byte_ready = 1'b1;
      @(negedge clk);
      send_byte(8'hA2);
      push_word(32'hEEEE_EE38);
      repeat (4) @(negedge clk);
      check(n_w - wb == 2 && cap_w[(wb + 1) % 256] == 32'hA200_0000, "R8 resume tx",
            cap_w[(wb + 1) % 256], 32'hA200_0000);
      check(n_b - bb == 2 && cap_b[(bb + 1) % 256] == 8'h38, "R8 resume rx",
            32'(cap_b[(bb + 1) % 256]), 32'h38);

      // R6/R7: no transmit data, no receive buffer, 2-byte words, length 5
      wb = n_w; bb = n_b;
      do_start(5'd15, 5, 1'b1, 1'b1);
      check(!tx_byte_ready, "R6 byte input closed", {31'd0, tx_byte_ready}, 32'd0);
      for (int k = 0; k < 3; k++) push_word(32'h1234_5678);
      repeat (4) @(negedge clk);
      check(n_w - wb == 3, "R6 zero word count", 32'(n_w - wb), 32'd3);
      for (int k = 0; k < 3; k++)
         check(cap_w[(wb + k) % 256] == 32'd0, "R6 zero word", cap_w[(wb + k) % 256], 32'd0);
      check(n_b - bb == 0, "R7 no bytes emitted", 32'(n_b - bb), 32'd0);
      check(rx_done && !ififo_ready, "R7 R9 discard done", {30'd0, rx_done, ififo_ready}, 32'd2);

      // R9: start clears done
      do_start(5'd7, 3, 1'b0, 1'b0);
      check(!rx_done && !tx_done, "R9 cleared by start", {30'd0, rx_done, tx_done}, 32'd0);
      bb = n_b;
      push_word(32'hEEEE_EE01);
      push_word(32'hEEEE_EE02);
      @(negedge clk);
      check(!rx_done, "R9 not early", {31'd0, rx_done}, 32'd0);
      push_word(32'hEEEE_EE03);
      repeat (3) @(negedge clk);
      check(rx_done && n_b - bb == 3, "R9 done at length", {31'd0, rx_done}, 32'd1);

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule